// File: doc/BRIEF.md
# Thread Interrupt Context Presenter

This block keeps the interrupt context of one hardware thread for two privilege rings: an operating-system ring and a hypervisor physical ring. Each ring holds a pending bitmap with eight priority levels, a pending priority derived from that bitmap, a current processor priority and a notification status byte. A ring signals an exception whenever its pending priority is more favoured than its current priority. The status bits of both rings drive one interrupt output.

Software reaches the context through a memory-mapped window of 4 KiB, seen either from an OS page or from an HV page. Plain byte reads at the low offsets return the ring registers. A small table selects the operations that have side effects. Each table entry is matched on page, offset, access size and direction. The operations are priority changes, the hypervisor context byte push and poll, the acknowledge reads at 2 KiB and above, and a pull that reads and clears the pool context identifier. Interrupt sources post a priority into either ring through a separate strobe. A read returns its data on `rd_data` in the cycle after the access.

Top module: `tctx_presenter`

## Requirements
- R1: The pending priority is the index of the most significant set bit of the 8-bit pending bitmap, where bit 7 stands for priority 0 and bit 0 for priority 7. An empty bitmap gives 0xFF. Each bitmap resets to its parameter value, so the pending priority seen after reset is derived from that value.
- R2: A ring raises its exception when its pending priority is numerically lower than its current priority. On the OS ring the exception sets status bit 7, giving a status of 0x80.
- R3: On the HV ring the exception writes the 2-bit field in status bits 7:6 with the physical code 01, giving a status of 0x40.
- R4: `irq` is high, starting one cycle after a status update, while the status byte of either ring is non-zero.
- R5: A 1-byte write sets the current priority to `acc_wdata[7:0]`. On the OS page it targets the OS ring at offset 0x011. On the HV page it targets the HV ring at offset 0x031. Notification is evaluated again afterwards.
- R6: A 2-byte read acknowledges a ring. Offset 0x810 on the OS page acknowledges the OS ring, and offset 0x830 on the HV page acknowledges the HV ring. The read returns the status in bits 15:8 and the pending priority in bits 7:0. Then the current priority takes the old pending priority, that priority's bitmap bit is cleared, and the status is cleared.
- R7: On the HV page, a 1-byte write to offset 0x038 stores `acc_wdata[7:0]` as the HV context byte. A 1-byte read of the same offset returns that byte.
- R8: On the HV page, a 4-byte write to offset 0x028 loads the 32-bit pool context word. A 4-byte or 8-byte read of offset 0x828 returns that word masked by `POOL_CAM_MASK` and clears the masked bits in the same access.
- R9: An access whose page, offset, size and direction match no entry has no side effect, and a read of that kind returns zero.
- R10: A 1-byte read on either page returns a ring register. Offsets 0x010 to 0x013 address the OS ring and 0x030 to 0x033 the HV ring. Byte 0 is the status, byte 1 the current priority, byte 2 the bitmap and byte 3 the pending priority.
- R11: A pulse on `post_valid` sets bit 7-`post_prio` of the bitmap of the ring that `post_ring` selects, where 0 is OS and 1 is HV.
- R12: After reset the current priorities, the status bytes, the context byte and the pool word are zero, and `irq` is low.
- R13: `acc_size` gives the access width as log2 of the byte count: 0 for 1 byte, 1 for 2, 2 for 4 and 3 for 8. `acc_page` is 0 for the OS page and 1 for the HV page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Post a pending priority |
| post_ring | input | 1 | Ring of the post: 0 OS, 1 HV |
| post_prio | input | 3 | Priority being posted |
| acc_valid | input | 1 | Window access strobe |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_page | input | 1 | 0 for the OS page, 1 for the HV page |
| acc_offset | input | 12 | Byte offset inside the window |
| acc_size | input | 2 | log2 of the access size in bytes |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 64 | Read data, one cycle after the access |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with an OS bitmap reset value of 0x24 and an HV reset value of 0x00. One ring therefore starts with pending priority 2, and the other starts empty at 0xFF. This makes the derivation at reset and the first acknowledge visible without any posting. The pool mask keeps its default of 0x00FFFFFF, so a pull of a word with upper bits set shows both the masked return and the bits that stay untouched. The random phase picks offsets near each table entry with every size and both pages. It therefore reaches the near-miss cases that must have no side effect.

// File: rtl/tctx_pkg.sv
package tctx_pkg;

  localparam int PRIO_W = 8;
  localparam int OFF_W  = 12;

  // window offsets
  localparam logic [OFF_W-1:0] OFF_OS_CPPR   = 12'h011;
  localparam logic [OFF_W-1:0] OFF_HV_CPPR   = 12'h031;
  localparam logic [OFF_W-1:0] OFF_POOL_WORD = 12'h028;
  localparam logic [OFF_W-1:0] OFF_HV_CTX    = 12'h038;
  localparam logic [OFF_W-1:0] OFF_ACK_OS    = 12'h810;
  localparam logic [OFF_W-1:0] OFF_ACK_HV    = 12'h830;
  localparam logic [OFF_W-1:0] OFF_PULL_POOL = 12'h828;

  localparam logic [7:0] NO_PRIO = 8'hFF;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_RD_REG,
    OP_CPPR_OS,
    OP_CPPR_HV,
    OP_CTX_PUSH,
    OP_CTX_POLL,
    OP_ACK_OS,
    OP_ACK_HV,
    OP_POOL_LOAD,
    OP_POOL_PULL
  } tctx_op_e;

  // most significant set bit of the bitmap, bit 7 = priority 0
  function automatic logic [7:0] pend_to_prio(input logic [7:0] pend);
    logic [7:0] p;
    p = NO_PRIO;
    for (int i = 7; i >= 0; i--) begin
      if (pend[i] && p == NO_PRIO) p = 8'(7 - i);
    end
    return p;
  endfunction

  // bitmap bit that stands for a 3-bit priority
  function automatic logic [7:0] prio_bit(input logic [2:0] prio);
    return 8'h80 >> prio;
  endfunction

endpackage

// File: rtl/tctx_ring.sv
module tctx_ring
  import tctx_pkg::*;
#(
  parameter logic [7:0] EXC_CODE = 8'h80,
  parameter logic [7:0] PEND_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       post_en,
  input  logic [2:0] post_prio,
  input  logic       cppr_we,
  input  logic [7:0] cppr_wval,
  input  logic       ack_en,
  output logic [7:0] nsr,
  output logic [7:0] cppr,
  output logic [7:0] pend,
  output logic [7:0] pipr,
  output logic       exc_hit
);

  logic [7:0] pend_nxt;
  logic [7:0] nsr_nxt;
  logic [7:0] cppr_nxt;
  logic       ack_has_prio;

  assign pipr         = pend_to_prio(pend);
  assign exc_hit      = (pipr < cppr);
  assign ack_has_prio = (pipr != NO_PRIO);

  always_comb begin
    pend_nxt = pend;
    if (ack_en && ack_has_prio) pend_nxt = pend_nxt & ~prio_bit(pipr[2:0]);
    if (post_en)                pend_nxt = pend_nxt | prio_bit(post_prio);
  end

  always_comb begin
    cppr_nxt = cppr;
    if (ack_en)       cppr_nxt = pipr;
    else if (cppr_we) cppr_nxt = cppr_wval;
  end

  always_comb begin
    nsr_nxt = nsr;
    if (ack_en)       nsr_nxt = 8'h00;
    else if (exc_hit) nsr_nxt = nsr | EXC_CODE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= PEND_RST;
      cppr <= 8'h00;
      nsr  <= 8'h00;
    end else begin
      pend <= pend_nxt;
      cppr <= cppr_nxt;
      nsr  <= nsr_nxt;
    end
  end

  // status byte only ever holds the ring's own code (R2, R3)
  p_nsr_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nsr == 8'h00) || (nsr == EXC_CODE));

  // status can only rise after pending was more favoured than current (R2)
  p_rise_needs_favoured_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nsr != 8'h00) |-> $past(pipr < cppr));

  // acknowledge clears status and moves the priority (R6)
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> (nsr == 8'h00) && (cppr == $past(pipr)));

endmodule

// File: rtl/tctx_decode.sv
module tctx_decode
  import tctx_pkg::*;
(
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic                 acc_page,
  input  logic [OFF_W-1:0]     acc_offset,
  input  logic [1:0]           acc_size,
  output tctx_op_e             op
);

  localparam logic PG_OS = 1'b0;
  localparam logic PG_HV = 1'b1;
  localparam logic [1:0] SZ1 = 2'd0;
  localparam logic [1:0] SZ2 = 2'd1;
  localparam logic [1:0] SZ4 = 2'd2;
  localparam logic [1:0] SZ8 = 2'd3;

  logic rd;
  logic wr;
  logic reg_hit;

  assign rd = acc_valid && !acc_write;
  assign wr = acc_valid &&  acc_write;

  // byte registers of the OS (0x01x) and HV (0x03x) rings
  assign reg_hit = (acc_offset[11:6] == 6'd0) && (acc_offset[3:2] == 2'd0) &&
                   acc_offset[4];

  always_comb begin
    op = OP_NONE;
    if (wr && acc_size == SZ1 && acc_page == PG_OS && acc_offset == OFF_OS_CPPR)
      op = OP_CPPR_OS;
    else if (wr && acc_size == SZ1 && acc_page == PG_HV && acc_offset == OFF_HV_CPPR)
      op = OP_CPPR_HV;
    else if (wr && acc_size == SZ1 && acc_page == PG_HV && acc_offset == OFF_HV_CTX)
      op = OP_CTX_PUSH;
    else if (rd && acc_size == SZ1 && acc_page == PG_HV && acc_offset == OFF_HV_CTX)
      op = OP_CTX_POLL;
    else if (wr && acc_size == SZ4 && acc_page == PG_HV && acc_offset == OFF_POOL_WORD)
      op = OP_POOL_LOAD;
    else if (rd && acc_size == SZ2 && acc_page == PG_OS && acc_offset == OFF_ACK_OS)
      op = OP_ACK_OS;
    else if (rd && acc_size == SZ2 && acc_page == PG_HV && acc_offset == OFF_ACK_HV)
      op = OP_ACK_HV;
    else if (rd && (acc_size == SZ4 || acc_size == SZ8) && acc_page == PG_HV &&
             acc_offset == OFF_PULL_POOL)
      op = OP_POOL_PULL;
    else if (rd && acc_size == SZ1 && reg_hit)
      op = OP_RD_REG;
  end

endmodule

// File: rtl/tctx_presenter.sv
module tctx_presenter
  import tctx_pkg::*;
#(
  parameter logic [7:0]  OS_PEND_RST   = 8'h00,
  parameter logic [7:0]  HV_PEND_RST   = 8'h00,
  parameter logic [31:0] POOL_CAM_MASK = 32'h00FF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        post_valid,
  input  logic        post_ring,
  input  logic [2:0]  post_prio,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic        acc_page,
  input  logic [11:0] acc_offset,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  output logic [63:0] rd_data,
  output logic        irq
);

  localparam int NRING = 2;

  tctx_op_e   op;
  logic [7:0] ring_nsr  [NRING];
  logic [7:0] ring_cppr [NRING];
  logic [7:0] ring_pend [NRING];
  logic [7:0] ring_pipr [NRING];
  logic       ring_exc  [NRING];
  logic [NRING-1:0] ring_ack;
  logic [NRING-1:0] ring_cppr_we;
  logic [31:0] pool_word;
  logic [7:0]  hv_ctx;
  logic [63:0] rd_val;
  logic        pool_pull;
  logic        reg_sel;

  tctx_decode u_dec (
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_page   (acc_page),
    .acc_offset (acc_offset),
    .acc_size   (acc_size),
    .op         (op)
  );

  assign ring_ack[0]     = (op == OP_ACK_OS);
  assign ring_ack[1]     = (op == OP_ACK_HV);
  assign ring_cppr_we[0] = (op == OP_CPPR_OS);
  assign ring_cppr_we[1] = (op == OP_CPPR_HV);
  assign pool_pull       = (op == OP_POOL_PULL);

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    localparam logic [7:0] CODE = (g == 0) ? 8'h80 : 8'h40;
    localparam logic [7:0] PRST = (g == 0) ? OS_PEND_RST : HV_PEND_RST;
    tctx_ring #(
      .EXC_CODE (CODE),
      .PEND_RST (PRST)
    ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .post_en   (post_valid && (post_ring == 1'(g))),
      .post_prio (post_prio),
      .cppr_we   (ring_cppr_we[g]),
      .cppr_wval (acc_wdata[7:0]),
      .ack_en    (ring_ack[g]),
      .nsr       (ring_nsr[g]),
      .cppr      (ring_cppr[g]),
      .pend      (ring_pend[g]),
      .pipr      (ring_pipr[g]),
      .exc_hit   (ring_exc[g])
    );
  end

  assign irq = (ring_nsr[0] != 8'h00) || (ring_nsr[1] != 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pool_word <= 32'h0;
      hv_ctx    <= 8'h00;
    end else begin
      if (op == OP_POOL_LOAD) pool_word <= acc_wdata;
      else if (pool_pull)     pool_word <= pool_word & ~POOL_CAM_MASK;
      if (op == OP_CTX_PUSH)  hv_ctx    <= acc_wdata[7:0];
    end
  end

  assign reg_sel = acc_offset[5];

  always_comb begin
    rd_val = 64'h0;
    case (op)
      OP_RD_REG: begin
        case (acc_offset[1:0])
          2'd0:    rd_val[7:0] = ring_nsr[reg_sel];
          2'd1:    rd_val[7:0] = ring_cppr[reg_sel];
          2'd2:    rd_val[7:0] = ring_pend[reg_sel];
          default: rd_val[7:0] = ring_pipr[reg_sel];
        endcase
      end
      OP_ACK_OS:    rd_val[15:0] = {ring_nsr[0], ring_pipr[0]};
      OP_ACK_HV:    rd_val[15:0] = {ring_nsr[1], ring_pipr[1]};
      OP_CTX_POLL:  rd_val[7:0]  = hv_ctx;
      OP_POOL_PULL: rd_val[31:0] = pool_word & POOL_CAM_MASK;
      default:      rd_val       = 64'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= 64'h0;
    else        rd_data <= rd_val;
  end

  // interrupt only rises after some ring saw a favoured pending priority (R4)
  p_irq_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ring_exc[0] || ring_exc[1]));

  // a pull leaves the identifier field cleared (R8)
  p_pull_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pool_pull |=> ((pool_word & POOL_CAM_MASK) == 32'h0));

  // unmatched access returns zero and keeps the stored words (R9)
  p_unmatched_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && op == OP_NONE) |=> (rd_data == 64'h0) && $stable(pool_word) &&
                                      $stable(hv_ctx));

  // at most one ring is acknowledged per access (R6)
  p_single_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ring_ack));

endmodule

// File: tb/sim_tctx_presenter.sv
`timescale 1ns/1ps
module sim_tctx_presenter;

  localparam logic [7:0]  OS_RST = 8'h24;
  localparam logic [7:0]  HV_RST = 8'h00;
  localparam logic [31:0] MASK   = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        post_valid = 1'b0;
  logic        post_ring = 1'b0;
  logic [2:0]  post_prio = 3'd0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_page = 1'b0;
  logic [11:0] acc_offset = 12'h0;
  logic [1:0]  acc_size = 2'd0;
  logic [31:0] acc_wdata = 32'h0;
  logic [63:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  logic [7:0]  m_pend [2];
  logic [7:0]  m_cppr [2];
  logic [7:0]  m_nsr  [2];
  logic [7:0]  m_ctx;
  logic [31:0] m_pool;
  logic [63:0] got;

  always #10 clk = ~clk;

  tctx_presenter #(
    .OS_PEND_RST   (OS_RST),
    .HV_PEND_RST   (HV_RST),
    .POOL_CAM_MASK (MASK)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .post_valid (post_valid),
    .post_ring  (post_ring),
    .post_prio  (post_prio),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_page   (acc_page),
    .acc_offset (acc_offset),
    .acc_size   (acc_size),
    .acc_wdata  (acc_wdata),
    .rd_data    (rd_data),
    .irq        (irq)
  );

  function automatic logic [7:0] b_prio(input logic [7:0] pend);
    logic [7:0] p = 8'hFF;
    for (int i = 0; i < 8; i++) if (pend[i]) p = 8'(7 - i);
    return p;
  endfunction

  function automatic logic [7:0] b_code(input int r);
    return (r == 0) ? 8'h80 : 8'h40;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    for (int r = 0; r < 2; r++)
      if (b_prio(m_pend[r]) < m_cppr[r]) m_nsr[r] = m_nsr[r] | b_code(r);
  endtask

  task automatic post(input int r, input logic [2:0] p);
    @(negedge clk);
    post_valid = 1'b1; post_ring = 1'(r); post_prio = p;
    @(negedge clk);
    post_valid = 1'b0;
    @(negedge clk);
    m_pend[r] = m_pend[r] | (8'h01 << (7 - p));
    settle();
  endtask

  // model of one access: returns the expected read and applies side effects
  task automatic model_access(input bit w, input bit pg, input logic [11:0] off,
                              input logic [1:0] sz, input logic [31:0] wd,
                              output logic [63:0] exp);
    int r;
    logic [7:0] pp;
    exp = 64'h0;
    if (w) begin
      if (sz == 0 && !pg && off == 12'h011) m_cppr[0] = wd[7:0];
      else if (sz == 0 && pg && off == 12'h031) m_cppr[1] = wd[7:0];
      else if (sz == 0 && pg && off == 12'h038) m_ctx = wd[7:0];
      else if (sz == 2 && pg && off == 12'h028) m_pool = wd;
    end else begin
      if (sz == 1 && ((!pg && off == 12'h810) || (pg && off == 12'h830))) begin
        r = pg ? 1 : 0;
        pp = b_prio(m_pend[r]);
        exp = {48'h0, m_nsr[r], pp};
        m_cppr[r] = pp;
        if (pp != 8'hFF) m_pend[r] = m_pend[r] & ~(8'h01 << (7 - pp));
        m_nsr[r] = 8'h00;
      end else if (sz >= 2 && pg && off == 12'h828) begin
        exp = {32'h0, m_pool & MASK};
        m_pool = m_pool & ~MASK;
      end else if (sz == 0 && pg && off == 12'h038) begin
        exp = {56'h0, m_ctx};
      end else if (sz == 0 && (off == 12'h010 || off == 12'h011 || off == 12'h012 ||
                               off == 12'h013 || off == 12'h030 || off == 12'h031 ||
                               off == 12'h032 || off == 12'h033)) begin
        r = (off >= 12'h030) ? 1 : 0;
        case (off[1:0])
          2'd0: exp = {56'h0, m_nsr[r]};
          2'd1: exp = {56'h0, m_cppr[r]};
          2'd2: exp = {56'h0, m_pend[r]};
          default: exp = {56'h0, b_prio(m_pend[r])};
        endcase
      end
    end
    settle();
  endtask

  task automatic access(input string tag, input bit w, input bit pg,
                        input logic [11:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [63:0] rd);
    logic [63:0] exp;
    model_access(w, pg, off, sz, wd, exp);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_page = pg;
    acc_offset = off; acc_size = sz; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0;
    rd = rd_data;
    if (!w) chk(tag, rd, exp);
    @(negedge clk);
    chk({tag, " irq"}, {63'h0, irq}, {63'h0, (m_nsr[0] != 0) || (m_nsr[1] != 0)});
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20190310);
    m_pend[0] = OS_RST; m_pend[1] = HV_RST;
    m_cppr[0] = 0; m_cppr[1] = 0; m_nsr[0] = 0; m_nsr[1] = 0;
    m_ctx = 0; m_pool = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12: reset state
    chk("R12 irq after reset", {63'h0, irq}, 64'h0);
    access("R1 OS pending prio from reset bitmap", 0, 0, 12'h013, 0, 0, got);
    chk("R1 OS prio literal", got, 64'h02);
    access("R1 HV empty bitmap", 0, 1, 12'h033, 0, 0, got);
    chk("R1 HV prio literal", got, 64'hFF);
    access("R12 OS cppr reset", 0, 0, 12'h011, 0, 0, got);
    chk("R12 cppr literal", got, 64'h00);

    // R5 / R2 / R4: OS priority opens, exception fires
    access("R5 OS cppr write", 1, 0, 12'h011, 0, 32'hFF, got);
    chk("R4 irq raised by OS", {63'h0, irq}, 64'h1);
    access("R2 OS status code", 0, 1, 12'h010, 0, 0, got);
    chk("R2 OS status literal", got, 64'h80);

    // R6: OS acknowledge
    access("R6 OS ack", 0, 0, 12'h810, 1, 0, got);
    chk("R6 OS ack literal", got, 64'h8002);
    chk("R6 irq dropped", {63'h0, irq}, 64'h0);
    access("R6 OS cppr after ack", 0, 0, 12'h011, 0, 0, got);
    chk("R6 cppr literal", got, 64'h02);
    access("R6 OS next pending", 0, 0, 12'h013, 0, 0, got);
    chk("R6 next prio literal", got, 64'h05);

    // R11 / R3: HV ring
    post(1, 3'd3);
    access("R11 HV bitmap after post", 0, 1, 12'h032, 0, 0, got);
    chk("R11 bitmap literal", got, 64'h10);
    access("R5 HV cppr write", 1, 1, 12'h031, 0, 32'h104, got);
    access("R3 HV status code", 0, 0, 12'h030, 0, 0, got);
    chk("R3 HV status literal", got, 64'h40);
    access("R9 HV cppr on OS page", 1, 0, 12'h031, 0, 32'h07, got);
    access("R9 HV cppr unchanged", 0, 1, 12'h031, 0, 0, got);
    chk("R9 cppr literal", got, 64'h04);
    access("R9 ack with wrong size", 0, 1, 12'h830, 0, 0, got);
    access("R6 HV ack", 0, 1, 12'h830, 1, 0, got);
    chk("R6 HV ack literal", got, 64'h4003);

    // R7: context byte
    access("R7 ctx push", 1, 1, 12'h038, 0, 32'h5A, got);
    access("R9 ctx 2-byte write ignored", 1, 1, 12'h038, 1, 32'h33, got);
    access("R7 ctx poll", 0, 1, 12'h038, 0, 0, got);
    chk("R7 ctx literal", got, 64'h5A);

    // R8: pool pull
    access("R8 pool load", 1, 1, 12'h028, 2, 32'hA512_3456, got);
    access("R9 pull with 2-byte size", 0, 1, 12'h828, 1, 0, got);
    access("R8 pull 4-byte", 0, 1, 12'h828, 2, 0, got);
    chk("R8 pull literal", got, 64'h0012_3456);
    access("R8 pull after clear", 0, 1, 12'h828, 3, 0, got);
    chk("R8 cleared literal", got, 64'h0);
    access("R8 pool reload", 1, 1, 12'h028, 2, 32'h0BAD_CAFE, got);
    access("R8 pull 8-byte", 0, 1, 12'h828, 3, 0, got);
    chk("R8 pull8 literal", got, 64'h00AD_CAFE);

    // random phase (R10, R13 and all the above mixed)
    for (int n = 0; n < 500; n++) begin
      logic [11:0] off;
      logic [31:0] wd;
      int k;
      k = int'($urandom % 14);
      case (k)
        0:  off = 12'h010 + 12'($urandom % 4);
        1:  off = 12'h030 + 12'($urandom % 4);
        2:  off = 12'h011;
        3:  off = 12'h031;
        4:  off = 12'h038;
        5:  off = 12'h028;
        6:  off = 12'h810;
        7:  off = 12'h830;
        8:  off = 12'h828;
        9:  off = 12'h014 + 12'($urandom % 8);
        default: off = 12'($urandom);
      endcase
      wd = $urandom;
      if (wd[31]) wd[7:0] = 8'($urandom % 9);
      if ($urandom % 4 == 0) post(int'($urandom % 2), 3'($urandom));
      access("R10 R13 random access", 1'($urandom), 1'($urandom), off,
             2'($urandom), wd, got);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule